// File: doc/BRIEF.md
# Dual-Layer Frame Store Compositor

The compositor drives a colour LCD from two 8-bit-per-pixel picture buffers. Layer A is fixed to the screen. Layer B can be shifted in both directions, and its coordinates wrap at the buffer edges. For every visible pixel the block fetches one byte from each buffer. It merges the two bytes under a programmable layering rule, turns the low six bits of the result into a 3-bit RGB colour, and packs the colour bits end to end into 8-bit display words. The display timing is its own: a one-clock frame pulse, a one-clock line pulse and a one-clock strobe for each data byte.

Each buffer holds 2^BX_W columns by 2^BY_W rows, and only H_VIS by V_VIS of them are shown. The buffers sit outside the block as synchronous-read memories with a one-clock read latency. Clocks alternate between two slots. In the display slot the block fetches a pixel pair. In the other slot a processor port may read both layers at one address in a single access, or write one layer. Three configuration registers hold the layering mode and the two scroll offsets. A panel enable output stays off until software has chosen a mode once.

Top module: `fb_compositor`

## Requirements
- R1: While reset is held, lcd_en is 0, lcd_frame_n and lcd_line_n are 1, and lcd_dclk is 0.
- R2: lcd_en becomes 1 on the clock after the first write with cfg_sel = 0 (mode) and stays 1 until reset. Writes to the other registers (cfg_sel = 1 horizontal scroll, cfg_sel = 2 vertical scroll) do not set it.
- R3: Mode 0 shows layer A, except where the whole 8-bit A value is 0; there it shows layer B.
- R4: Mode 1 shows layer B, except where the whole 8-bit B value is 0; there it shows layer A.
- R5: Mode 2 shows layer A only, including A pixels whose value is 0.
- R6: Mode 3 shows layer B only.
- R7: Buffer addresses are {row, column}, with the column in the low BX_W bits. Screen pixel (x, y) takes A from (x, y) and takes B from ((x + scroll_x) mod 2^BX_W, (y + scroll_y) mod 2^BY_W).
- R8: The colour of a chosen pixel p is r = p[5], g = p[3], b = p[1]. Bits 7 and 6 do not affect the colour.
- R9: Each visible line forms a bit stream r, g, b of pixel 0, then of pixel 1, and so on. The stream is cut into bytes with the earliest bit at bit 7, giving H_VIS*3/8 bytes per line. lcd_dclk is high for exactly one clock with each byte on lcd_data.
- R10: lcd_line_n goes low for one clock at the start of each visible line. lcd_frame_n goes low for one clock only together with the line pulse of row 0. There are V_VIS line pulses per frame.
- R11: cpu_slot alternates every clock. A read request sampled while cpu_slot is 1 returns {B byte, A byte} on cpu_rdata, with cpu_rvalid high for one clock, after the second following clock edge.
- R12: A write sampled while cpu_slot is 1 changes only the layer chosen by cpu_layer (0 = A, 1 = B), at cpu_addr. The other layer is unchanged, and the display uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 mode, 1 scroll x, 2 scroll y |
| cfg_wdata | input | max(BX_W,BY_W) | Configuration write data |
| cpu_req | input | 1 | Processor access request, taken while cpu_slot is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_layer | input | 1 | Layer chosen for a write: 0 = A, 1 = B |
| cpu_addr | input | BX_W+BY_W | Processor address {row, column} |
| cpu_wdata | input | 8 | Processor write data |
| cpu_slot | output | 1 | High in clocks that belong to the processor |
| cpu_rdata | output | 16 | Read result {B byte, A byte} |
| cpu_rvalid | output | 1 | Read result valid, one clock |
| ma_addr | output | BX_W+BY_W | Layer A memory address |
| ma_we | output | 1 | Layer A memory write enable |
| ma_wdata | output | 8 | Layer A memory write data |
| ma_rdata | input | 8 | Layer A memory read data, one clock after address |
| mb_addr | output | BX_W+BY_W | Layer B memory address |
| mb_we | output | 1 | Layer B memory write enable |
| mb_wdata | output | 8 | Layer B memory write data |
| mb_rdata | input | 8 | Layer B memory read data, one clock after address |
| lcd_frame_n | output | 1 | Active-low frame start pulse |
| lcd_line_n | output | 1 | Active-low line start pulse |
| lcd_data | output | 8 | Packed RGB display byte |
| lcd_dclk | output | 1 | Data strobe, one clock per byte |
| lcd_en | output | 1 | Panel enable |

## Verification
The pixel address is presented in a display-slot clock and returns at the next edge. The line and frame pulses are registered at that same edge. The pixel is merged during the following processor-slot clock, and any completed byte appears with lcd_dclk after the edge that ends it. For this reason the bench does not predict byte cycles: after each configuration change it waits for the next frame pulse and then takes bytes only on lcd_dclk, comparing them in order against a model of the layering, the colour mapping and the bit packing. Register results are sampled on the falling edge right after the write clock. A processor read is sampled on the second falling edge after the request clock, which is when R11 places cpu_rvalid.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int PIX_W    = 8;
    localparam int BYTE_W   = 8;
    localparam int RGB_BITS = 3;

    typedef enum logic [1:0] {
        MODE_A_OVER_B = 2'd0,
        MODE_B_OVER_A = 2'd1,
        MODE_A_ONLY   = 2'd2,
        MODE_B_ONLY   = 2'd3
    } layer_mode_e;

    typedef enum logic [1:0] {
        CFG_MODE     = 2'd0,
        CFG_SCROLL_X = 2'd1,
        CFG_SCROLL_Y = 2'd2,
        CFG_UNUSED   = 2'd3
    } cfg_sel_e;

    // Tag carried from the fetch clock to the merge clock
    typedef struct packed {
        logic visible;
        logic line_start;
    } fetch_tag_t;

    function automatic logic [PIX_W-1:0] pick_pixel(layer_mode_e m,
                                                    logic [PIX_W-1:0] a,
                                                    logic [PIX_W-1:0] b);
        case (m)
            MODE_A_OVER_B: return (a == '0) ? b : a;
            MODE_B_OVER_A: return (b == '0) ? a : b;
            MODE_A_ONLY:   return a;
            default:       return b;
        endcase
    endfunction

    // 64-entry colour table, computed: top bit of each 2-bit channel
    function automatic logic [RGB_BITS-1:0] colour_lookup(logic [PIX_W-1:0] p);
        return {p[5], p[3], p[1]};
    endfunction

endpackage

// File: rtl/fbc_timing.sv
module fbc_timing
    import fbc_pkg::*;
#(
    parameter int H_VIS   = 320,
    parameter int V_VIS   = 240,
    parameter int H_BLANK = 16,
    parameter int V_BLANK = 8,
    localparam int H_TOT  = H_VIS + H_BLANK,
    localparam int V_TOT  = V_VIS + V_BLANK,
    localparam int HC_W   = $clog2(H_TOT),
    localparam int VC_W   = $clog2(V_TOT)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            ph,
    output logic [HC_W-1:0] hcnt,
    output logic [VC_W-1:0] vcnt,
    output fetch_tag_t      tag,
    output logic            frame_n,
    output logic            line_n
);

    logic row_vis, col_vis, at_line0;

    always_comb begin
        row_vis  = vcnt < VC_W'(V_VIS);
        col_vis  = hcnt < HC_W'(H_VIS);
        at_line0 = (hcnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= 1'b0;
            hcnt    <= '0;
            vcnt    <= '0;
            tag     <= '0;
            frame_n <= 1'b1;
            line_n  <= 1'b1;
        end else begin
            ph      <= ~ph;
            frame_n <= 1'b1;
            line_n  <= 1'b1;
            if (!ph) begin
                tag.visible    <= row_vis && col_vis;
                tag.line_start <= row_vis && at_line0;
                line_n         <= !(row_vis && at_line0);
                frame_n        <= !(at_line0 && vcnt == '0);
                if (hcnt == HC_W'(H_TOT - 1)) begin
                    hcnt <= '0;
                    vcnt <= (vcnt == VC_W'(V_TOT - 1)) ? '0 : vcnt + 1'b1;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end
        end
    end

    // R10
    frame_in_line_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_n |-> !line_n);

    // R10
    line_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !line_n |=> line_n);

endmodule

// File: rtl/fbc_regs.sv
module fbc_regs
    import fbc_pkg::*;
#(
    parameter int BX_W  = 9,
    parameter int BY_W  = 8,
    localparam int CFG_W = (BX_W > BY_W) ? BX_W : BY_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    output layer_mode_e      mode,
    output logic [BX_W-1:0]  scroll_x,
    output logic [BY_W-1:0]  scroll_y,
    output logic             disp_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_A_OVER_B;
            scroll_x <= '0;
            scroll_y <= '0;
            disp_en  <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_MODE: begin
                    mode    <= layer_mode_e'(cfg_wdata[1:0]);
                    disp_en <= 1'b1;
                end
                CFG_SCROLL_X: scroll_x <= cfg_wdata[BX_W-1:0];
                CFG_SCROLL_Y: scroll_y <= cfg_wdata[BY_W-1:0];
                default: ;
            endcase
        end
    end

    // R2
    en_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        disp_en |=> disp_en);

    // R2
    en_on_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0) |=> disp_en);

endmodule

// File: rtl/fbc_fetch.sv
module fbc_fetch
    import fbc_pkg::*;
#(
    parameter int BX_W = 9,
    parameter int BY_W = 8,
    parameter int HC_W = 9,
    parameter int VC_W = 8,
    localparam int AW  = BX_W + BY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ph,
    input  logic [HC_W-1:0]    hcnt,
    input  logic [VC_W-1:0]    vcnt,
    input  logic [BX_W-1:0]    scroll_x,
    input  logic [BY_W-1:0]    scroll_y,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic               cpu_layer,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [PIX_W-1:0]   cpu_wdata,
    output logic [2*PIX_W-1:0] cpu_rdata,
    output logic               cpu_rvalid,
    output logic [AW-1:0]      ma_addr,
    output logic               ma_we,
    output logic [PIX_W-1:0]   ma_wdata,
    input  logic [PIX_W-1:0]   ma_rdata,
    output logic [AW-1:0]      mb_addr,
    output logic               mb_we,
    output logic [PIX_W-1:0]   mb_wdata,
    input  logic [PIX_W-1:0]   mb_rdata
);

    logic            cpu_go, rd_pend;
    logic [BX_W-1:0] col;
    logic [BY_W-1:0] row;

    always_comb begin
        cpu_go   = ph && cpu_req;
        col      = BX_W'(hcnt);
        row      = BY_W'(vcnt);
        ma_addr  = cpu_go ? cpu_addr : {row, col};
        mb_addr  = cpu_go ? cpu_addr : {row + scroll_y, col + scroll_x};
        ma_we    = cpu_go && cpu_we && !cpu_layer;
        mb_we    = cpu_go && cpu_we &&  cpu_layer;
        ma_wdata = cpu_wdata;
        mb_wdata = cpu_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend    <= 1'b0;
            cpu_rvalid <= 1'b0;
            cpu_rdata  <= '0;
        end else begin
            rd_pend    <= cpu_go && !cpu_we;
            cpu_rvalid <= rd_pend;
            if (rd_pend) cpu_rdata <= {mb_rdata, ma_rdata};
        end
    end

    // R11
    slot_alt_chk: assert property (@(posedge clk) disable iff (rst)
        ph |=> !ph);

    // R12
    we_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (ma_we || mb_we) |-> (ph && $onehot0({ma_we, mb_we})));

    // R11
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (ph && cpu_req && !cpu_we) |=> ##1 cpu_rvalid);

endmodule

// File: rtl/fbc_pack.sv
module fbc_pack
    import fbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ph,
    input  fetch_tag_t        tag,
    input  layer_mode_e       mode,
    input  logic [PIX_W-1:0]  a_pix,
    input  logic [PIX_W-1:0]  b_pix,
    output logic [BYTE_W-1:0] px_data,
    output logic              px_stb
);

    localparam int PEND_W = BYTE_W - 1;
    localparam int CMB_W  = PEND_W + RGB_BITS;
    localparam int CNT_W  = $clog2(CMB_W + 1);

    logic [PIX_W-1:0]    shown;
    logic [RGB_BITS-1:0] rgb;
    logic [PEND_W-1:0]   pend, base_pend;
    logic [CNT_W-1:0]    cnt, base_cnt, total, rem;
    logic [CMB_W-1:0]    cmb, mask;

    always_comb begin
        shown     = pick_pixel(mode, a_pix, b_pix);
        rgb       = colour_lookup(shown);
        base_pend = tag.line_start ? '0 : pend;
        base_cnt  = tag.line_start ? '0 : cnt;
        cmb       = {base_pend, rgb};
        total     = base_cnt + CNT_W'(RGB_BITS);
        rem       = total - CNT_W'(BYTE_W);
        mask      = (CMB_W'(1) << rem) - CMB_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= '0;
            cnt     <= '0;
            px_data <= '0;
            px_stb  <= 1'b0;
        end else begin
            px_stb <= 1'b0;
            if (ph && tag.visible) begin
                if (total >= CNT_W'(BYTE_W)) begin
                    px_data <= BYTE_W'(cmb >> rem);
                    pend    <= PEND_W'(cmb & mask);
                    cnt     <= rem;
                    px_stb  <= 1'b1;
                end else begin
                    pend <= PEND_W'(cmb);
                    cnt  <= total;
                end
            end
        end
    end

    // R9
    dclk_gap_chk: assert property (@(posedge clk) disable iff (rst)
        px_stb |=> !px_stb);

endmodule

// File: rtl/fb_compositor.sv
module fb_compositor
    import fbc_pkg::*;
#(
    parameter int BX_W    = 9,
    parameter int BY_W    = 8,
    parameter int H_VIS   = 320,
    parameter int V_VIS   = 240,
    parameter int H_BLANK = 16,
    parameter int V_BLANK = 8,
    localparam int AW     = BX_W + BY_W,
    localparam int CFG_W  = (BX_W > BY_W) ? BX_W : BY_W,
    localparam int HC_W   = $clog2(H_VIS + H_BLANK),
    localparam int VC_W   = $clog2(V_VIS + V_BLANK)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               cpu_req,
    input  logic               cpu_we,
    input  logic               cpu_layer,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [PIX_W-1:0]   cpu_wdata,
    output logic               cpu_slot,
    output logic [2*PIX_W-1:0] cpu_rdata,
    output logic               cpu_rvalid,
    output logic [AW-1:0]      ma_addr,
    output logic               ma_we,
    output logic [PIX_W-1:0]   ma_wdata,
    input  logic [PIX_W-1:0]   ma_rdata,
    output logic [AW-1:0]      mb_addr,
    output logic               mb_we,
    output logic [PIX_W-1:0]   mb_wdata,
    input  logic [PIX_W-1:0]   mb_rdata,
    output logic               lcd_frame_n,
    output logic               lcd_line_n,
    output logic [BYTE_W-1:0]  lcd_data,
    output logic               lcd_dclk,
    output logic               lcd_en
);

    logic            ph;
    logic [HC_W-1:0] hcnt;
    logic [VC_W-1:0] vcnt;
    fetch_tag_t      tag;
    layer_mode_e     mode;
    logic [BX_W-1:0] scroll_x;
    logic [BY_W-1:0] scroll_y;

    assign cpu_slot = ph;

    fbc_timing #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .H_BLANK(H_BLANK), .V_BLANK(V_BLANK)
    ) u_timing (
        .clk(clk), .rst(rst), .ph(ph), .hcnt(hcnt), .vcnt(vcnt),
        .tag(tag), .frame_n(lcd_frame_n), .line_n(lcd_line_n)
    );

    fbc_regs #(.BX_W(BX_W), .BY_W(BY_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mode(mode), .scroll_x(scroll_x),
        .scroll_y(scroll_y), .disp_en(lcd_en)
    );

    fbc_fetch #(.BX_W(BX_W), .BY_W(BY_W), .HC_W(HC_W), .VC_W(VC_W)) u_fetch (
        .clk(clk), .rst(rst), .ph(ph), .hcnt(hcnt), .vcnt(vcnt),
        .scroll_x(scroll_x), .scroll_y(scroll_y),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_layer(cpu_layer),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .ma_addr(ma_addr), .ma_we(ma_we), .ma_wdata(ma_wdata), .ma_rdata(ma_rdata),
        .mb_addr(mb_addr), .mb_we(mb_we), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
    );

    fbc_pack u_pack (
        .clk(clk), .rst(rst), .ph(ph), .tag(tag), .mode(mode),
        .a_pix(ma_rdata), .b_pix(mb_rdata),
        .px_data(lcd_data), .px_stb(lcd_dclk)
    );

endmodule

// File: tb/sim_fb_compositor.sv
module sim_fb_compositor;

    localparam int BX_W    = 5;
    localparam int BY_W    = 3;
    localparam int H_VIS   = 16;
    localparam int V_VIS   = 6;
    localparam int H_BLANK = 4;
    localparam int V_BLANK = 2;
    localparam int AW      = BX_W + BY_W;
    localparam int CFG_W   = (BX_W > BY_W) ? BX_W : BY_W;
    localparam int COLS    = 1 << BX_W;
    localparam int ROWS    = 1 << BY_W;
    localparam int DEPTH   = COLS * ROWS;
    localparam int BPL     = H_VIS * 3 / 8;
    localparam int NBYTES  = BPL * V_VIS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [CFG_W-1:0] cfg_wdata = '0;
    logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_layer = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic cpu_slot, cpu_rvalid;
    logic [15:0] cpu_rdata;
    logic [AW-1:0] ma_addr, mb_addr;
    logic ma_we, mb_we;
    logic [7:0] ma_wdata, mb_wdata, ma_rdata, mb_rdata;
    logic lcd_frame_n, lcd_line_n, lcd_dclk, lcd_en;
    logic [7:0] lcd_data;

    logic [7:0] mem_a [0:DEPTH-1];
    logic [7:0] mem_b [0:DEPTH-1];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    fb_compositor #(
        .BX_W(BX_W), .BY_W(BY_W), .H_VIS(H_VIS), .V_VIS(V_VIS),
        .H_BLANK(H_BLANK), .V_BLANK(V_BLANK)
    ) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_layer(cpu_layer), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_slot(cpu_slot), .cpu_rdata(cpu_rdata),
        .cpu_rvalid(cpu_rvalid),
        .ma_addr(ma_addr), .ma_we(ma_we), .ma_wdata(ma_wdata), .ma_rdata(ma_rdata),
        .mb_addr(mb_addr), .mb_we(mb_we), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata),
        .lcd_frame_n(lcd_frame_n), .lcd_line_n(lcd_line_n), .lcd_data(lcd_data),
        .lcd_dclk(lcd_dclk), .lcd_en(lcd_en)
    );

    always @(posedge clk) begin
        if (ma_we) mem_a[ma_addr] <= ma_wdata;
        if (mb_we) mem_b[mb_addr] <= mb_wdata;
        ma_rdata <= mem_a[ma_addr];
        mb_rdata <= mem_b[mb_addr];
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not complete, act=%0d exp=<100000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_pick(int m, logic [7:0] a, logic [7:0] b);
        case (m)
            0: return (a == 8'd0) ? b : a;
            1: return (b == 8'd0) ? a : b;
            2: return a;
            default: return b;
        endcase
    endfunction

    function automatic logic [7:0] exp_byte(int m, int sx, int sy, int y, int j);
        logic [7:0] r, a, b, p;
        int i, x, c;
        r = '0;
        for (int t = 0; t < 8; t++) begin
            i = j * 8 + t;
            x = i / 3;
            c = i % 3;
            a = mem_a[y * COLS + x];
            b = mem_b[((y + sy) % ROWS) * COLS + ((x + sx) % COLS)];
            p = model_pick(m, a, b);
            r[7 - t] = (c == 0) ? p[5] : (c == 1) ? p[3] : p[1];
        end
        return r;
    endfunction

    task automatic cfg_write(input logic [1:0] sel, input int val);
        cfg_sel   = sel;
        cfg_wdata = CFG_W'(val);
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cpu_access(input logic we, input logic layer, input int addr, input int wd);
        while (!cpu_slot) @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_layer = layer;
        cpu_addr  = AW'(addr);
        cpu_wdata = 8'(wd);
        @(negedge clk);
        cpu_req   = 1'b0;
        cpu_we    = 1'b0;
    endtask

    task automatic cpu_read_chk(input int addr, input string req);
        logic [15:0] expd;
        cpu_access(1'b0, 1'b0, addr, 0);
        expd = {mem_b[addr], mem_a[addr]};
        @(negedge clk);
        chk(req, "cpu_rvalid", int'(cpu_rvalid), 1);
        chk(req, "cpu_rdata", int'(cpu_rdata), int'(expd));
    endtask

    task automatic check_frame(input int m, input int sx, input int sy, input string req);
        int got, lines, bad;
        got = 0; lines = 0; bad = 0;
        while (lcd_frame_n) @(negedge clk);
        chk("R10", "line pulse with frame pulse", int'(lcd_line_n), 0);
        lines = 1;
        while (got < NBYTES) begin
            @(negedge clk);
            if (!lcd_frame_n) bad = bad + 1;
            if (!lcd_line_n) lines = lines + 1;
            if (lcd_dclk) begin
                chk(req, $sformatf("mode %0d byte %0d", m, got), int'(lcd_data),
                    int'(exp_byte(m, sx, sy, got / BPL, got % BPL)));
                got = got + 1;
            end
        end
        chk("R10", "line pulses per frame", lines, V_VIS);
        chk("R10", "extra frame pulses", bad, 0);
    endtask

    initial begin
        for (int y = 0; y < ROWS; y++) begin
            for (int x = 0; x < COLS; x++) begin
                mem_a[y * COLS + x] = ((x + y) % 3 == 0) ? 8'd0 : 8'((x * 7 + y * 13 + 5) & 255);
                mem_b[y * COLS + x] = ((x * 3 + y) % 4 == 0) ? 8'd0 : 8'((x * 11 + y * 29 + 8'h9A) & 255);
            end
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "lcd_en in reset", int'(lcd_en), 0);
        chk("R1", "frame_n in reset", int'(lcd_frame_n), 1);
        chk("R1", "line_n in reset", int'(lcd_line_n), 1);
        chk("R1", "dclk in reset", int'(lcd_dclk), 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 scroll write leaves enable off, mode write turns it on
        cfg_write(2'd1, 0);
        chk("R2", "lcd_en after scroll write", int'(lcd_en), 0);
        cfg_write(2'd0, 0);
        chk("R2", "lcd_en after mode write", int'(lcd_en), 1);

        check_frame(0, 0, 0, "R3");
        cfg_write(2'd0, 1);
        check_frame(1, 0, 0, "R4");
        cfg_write(2'd0, 2);
        check_frame(2, 0, 0, "R5");
        cfg_write(2'd0, 3);
        check_frame(3, 0, 0, "R6");
        chk("R2", "lcd_en stays on", int'(lcd_en), 1);

        // R7 wrap-around scroll of layer B
        cfg_write(2'd1, 25);
        cfg_write(2'd2, 5);
        check_frame(3, 25, 5, "R7");
        cfg_write(2'd0, 0);
        check_frame(0, 25, 5, "R7");
        cfg_write(2'd1, 0);
        cfg_write(2'd2, 0);

        // R11 / R12 processor access
        cpu_read_chk(2 * COLS + 3, "R11");
        cpu_access(1'b1, 1'b0, 2 * COLS + 3, 8'hC0);
        cpu_access(1'b1, 1'b1, 2 * COLS + 3, 8'h15);
        chk("R12", "A write landed", int'(mem_a[2 * COLS + 3]), 8'hC0);
        cpu_read_chk(2 * COLS + 3, "R11");
        cpu_access(1'b1, 1'b0, 1 * COLS + 4, 8'h33);
        cpu_read_chk(1 * COLS + 4, "R12");
        cpu_access(1'b1, 1'b1, 0, 8'h00);
        cpu_access(1'b1, 1'b0, 0, 8'h2A);

        // R8 pixel 0xC0 is opaque but black; R12 display sees the writes
        cfg_write(2'd0, 0);
        check_frame(0, 0, 0, "R8");
        cfg_write(2'd0, 2);
        check_frame(2, 0, 0, "R12");
        // R9 packing with a B-only screen after writes
        cfg_write(2'd0, 3);
        check_frame(3, 0, 0, "R9");

        summary();
        $finish;
    end

endmodule